// File: doc/BRIEF.md
# Serial Channel Command Controller

This block sits between the host write path and one serial channel. Each write of a command byte is decoded in a single cycle. The block keeps the enable state of the receive and transmit directions and raises one-cycle strobes that reset the neighbouring logic: the receiver, the transmitter, the error flags, the break-change interrupt flag and the mode-register pointer. It also tells the transmitter when its ready and empty flags must be set or cleared. A transmitter that has been switched off keeps running until the data it already holds has gone out.

The second task is to sequence a break on the serial output. The transmitter supplies a one-per-bit tick and two status lines: one says a character is being shifted, the other says the holding register is loaded. A requested break waits for queued traffic to finish, or for at most two bit times when the line is already quiet. It then pulls the line low until a stop request arrives, and finally keeps the line marking for one whole bit period before the transmitter may send again. All interfaces are plain control and status pins with no handshake. A command is a single-cycle write strobe that is never back-pressured.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: Command bit 0 turns the receiver on and bit 1 turns it off. When both bits are set in one write, the receiver ends up off. `rx_enable` updates on the clock edge that samples the write.
- R2: Command bit 2 turns the transmitter on and bit 3 turns it off, and off wins. An effective turn-on gives a one-cycle `tx_rdy_set_pulse`. Any write with bit 3 set gives a one-cycle `tx_stat_clr_pulse`.
- R3: Bits 6:4 carry one encoded action, and each action gives a one-cycle strobe after the write. The codes are: 001 mode pointer reset, 010 receiver reset, 011 transmitter reset, 100 error flag clear, 101 break-change flag clear, 110 break start, 111 break stop. Code 000 gives no strobe.
- R4: A receiver reset (010) clears `rx_enable` and a transmitter reset (011) clears `tx_enable`. If the same write also sets the matching enable bit (and not the disable bit), the reset acts first and the direction ends up enabled.
- R5: An effective receiver turn-on (bit 0 set, bit 1 clear) gives a one-cycle `rx_hunt_pulse`, which sends the receiver back to searching for a start bit.
- R6: After the transmitter is turned off, `tx_running` stays high while `tx_shifting` or `thr_loaded` is high. It falls one cycle after both are seen low. If the transmitter was idle when turned off, `tx_running` falls together with `tx_enable`.
- R7: Bit 7 of the command byte has no effect on any output.
- R8: A break start (110) is accepted only when `tx_enable` was already high before the write. Otherwise it is dropped and `tx_hold_off` stays low.
- R9: A break started while the transmitter is idle raises `tx_hold_off` at once. `tx_line_low` follows on the second `bit_tick` after that.
- R10: A break started while `tx_shifting` or `thr_loaded` is high waits, with both outputs low. `tx_line_low` rises one cycle after both inputs are seen low.
- R11: A break stop (111) during an active break keeps the line low until the next `bit_tick`. It then releases the line while `tx_hold_off` stays high until one further `bit_tick`.
- R12: A break stop before the line has gone low cancels the pending break. A transmitter reset ends any break phase at once, releasing both `tx_line_low` and `tx_hold_off`.
- R13: No strobe output is ever high in a cycle that does not follow a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte |
| bit_tick | input | 1 | One pulse per transmit bit period |
| tx_shifting | input | 1 | Transmitter is shifting a character |
| thr_loaded | input | 1 | Transmit holding register holds a character |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| tx_running | output | 1 | Transmitter enabled or still draining |
| rx_hunt_pulse | output | 1 | Force start-bit search |
| tx_rdy_set_pulse | output | 1 | Set transmitter ready flag |
| tx_stat_clr_pulse | output | 1 | Clear transmitter ready and empty flags |
| mr_ptr_rst_pulse | output | 1 | Reset mode-register pointer |
| rx_reset_pulse | output | 1 | Reset receiver and flush its FIFO |
| tx_reset_pulse | output | 1 | Reset transmitter |
| err_clr_pulse | output | 1 | Clear break, parity, framing and overrun flags |
| brk_chg_clr_pulse | output | 1 | Clear break-change interrupt flag |
| tx_hold_off | output | 1 | Transmitter must not start a new character |
| tx_line_low | output | 1 | Force serial output to spacing |

## Verification
The assertions assume the transmitter honours `tx_hold_off`. Once the hold is raised, `tx_shifting` and `thr_loaded` must stay low, so the line only goes low after a cycle in which both were low. The drain check also assumes that these status inputs fall only by themselves or through a transmitter reset. The bench therefore changes the status inputs only while no break hold is active. It keeps them low during the full sweep of all 256 command bytes, from every pair of starting enable states. Status inputs are raised only in the directed drain and break-wait cases.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  typedef enum logic [2:0] {
    MC_NONE   = 3'd0,
    MC_MRPTR  = 3'd1,
    MC_RXRST  = 3'd2,
    MC_TXRST  = 3'd3,
    MC_ERRCLR = 3'd4,
    MC_BRKCLR = 3'd5,
    MC_BRKGO  = 3'd6,
    MC_BRKEND = 3'd7
  } misc_cmd_e;

  typedef struct packed {
    logic      rx_on;
    logic      rx_off;
    logic      tx_on;
    logic      tx_off;
    misc_cmd_e misc;
  } cmd_s;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_WAIT,
    BK_DLY,
    BK_LOW,
    BK_END,
    BK_MARK
  } brk_state_e;

  localparam int NUM_STROBES = 5;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic       we,
  input  logic [6:0] wdata,
  output cmd_s       cmd
);
  always_comb begin
    cmd.rx_on  = we & wdata[0];
    cmd.rx_off = we & wdata[1];
    cmd.tx_on  = we & wdata[2];
    cmd.tx_off = we & wdata[3];
    cmd.misc   = we ? misc_cmd_e'(wdata[6:4]) : MC_NONE;
  end
endmodule

// File: rtl/uart_cmd_strobes.sv
module uart_cmd_strobes
  import uart_cmd_pkg::*;
#(
  parameter int NSTB = NUM_STROBES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  misc_cmd_e       misc,
  output logic [NSTB-1:0] strobe
);
  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    localparam logic [2:0] CODE = 3'(i + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) strobe[i] <= 1'b0;
      else        strobe[i] <= (misc == CODE);
    end
  end
endmodule

// File: rtl/uart_cmd_enables.sv
module uart_cmd_enables
  import uart_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_s cmd,
  input  logic tx_shifting,
  input  logic thr_loaded,
  output logic rx_enable,
  output logic tx_enable,
  output logic tx_running,
  output logic rx_hunt_pulse,
  output logic tx_rdy_set_pulse,
  output logic tx_stat_clr_pulse
);
  logic rx_q, tx_q, drain_q;
  logic rx_n, tx_n, drain_n;
  logic tx_busy;

  assign tx_busy = tx_shifting | thr_loaded;

  always_comb begin
    rx_n = rx_q;
    if (cmd.misc == MC_RXRST) rx_n = 1'b0;
    if (cmd.rx_on)            rx_n = 1'b1;
    if (cmd.rx_off)           rx_n = 1'b0;

    tx_n = tx_q;
    if (cmd.misc == MC_TXRST) tx_n = 1'b0;
    if (cmd.tx_on)            tx_n = 1'b1;
    if (cmd.tx_off)           tx_n = 1'b0;

    if (cmd.misc == MC_TXRST || tx_n) drain_n = 1'b0;
    else if (cmd.tx_off)              drain_n = tx_busy;
    else if (drain_q)                 drain_n = tx_busy;
    else                              drain_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q              <= 1'b0;
      tx_q              <= 1'b0;
      drain_q           <= 1'b0;
      rx_hunt_pulse     <= 1'b0;
      tx_rdy_set_pulse  <= 1'b0;
      tx_stat_clr_pulse <= 1'b0;
    end else begin
      rx_q              <= rx_n;
      tx_q              <= tx_n;
      drain_q           <= drain_n;
      rx_hunt_pulse     <= cmd.rx_on & ~cmd.rx_off;
      tx_rdy_set_pulse  <= cmd.tx_on & ~cmd.tx_off;
      tx_stat_clr_pulse <= cmd.tx_off;
    end
  end

  assign rx_enable  = rx_q;
  assign tx_enable  = tx_q;
  assign tx_running = tx_q | drain_q;
endmodule

// File: rtl/uart_brk_seq.sv
module uart_brk_seq
  import uart_cmd_pkg::*;
#(
  parameter int START_TICKS = 2,
  parameter int MARK_TICKS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic kill_req,
  input  logic tx_en_q,
  input  logic bit_tick,
  input  logic tx_shifting,
  input  logic thr_loaded,
  output logic tx_hold_off,
  output logic tx_line_low
);
  localparam int MAXT  = (START_TICKS > MARK_TICKS) ? START_TICKS : MARK_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_TICKS - 1);
  localparam logic [CNT_W-1:0] MARK_LAST  = CNT_W'(MARK_TICKS - 1);

  brk_state_e st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic busy;

  assign busy = tx_shifting | thr_loaded;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (kill_req) begin
      st_n  = BK_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        BK_IDLE: if (start_req && tx_en_q) begin
          st_n  = busy ? BK_WAIT : BK_DLY;
          cnt_n = '0;
        end
        BK_WAIT: begin
          if (stop_req)   st_n = BK_IDLE;
          else if (!busy) st_n = BK_LOW;
        end
        BK_DLY: begin
          if (stop_req) st_n = BK_IDLE;
          else if (bit_tick) begin
            if (cnt_q == START_LAST) begin
              st_n  = BK_LOW;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        BK_LOW: if (stop_req) st_n = BK_END;
        BK_END: if (bit_tick) begin
          st_n  = BK_MARK;
          cnt_n = '0;
        end
        BK_MARK: if (bit_tick) begin
          if (cnt_q == MARK_LAST) st_n = BK_IDLE;
          else                    cnt_n = cnt_q + 1'b1;
        end
        default: st_n = BK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign tx_line_low = (st_q == BK_LOW) || (st_q == BK_END);
  assign tx_hold_off = (st_q == BK_DLY) || tx_line_low || (st_q == BK_MARK);
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int START_TICKS = 2,
  parameter int MARK_TICKS  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  input  logic       bit_tick,
  input  logic       tx_shifting,
  input  logic       thr_loaded,
  output logic       rx_enable,
  output logic       tx_enable,
  output logic       tx_running,
  output logic       rx_hunt_pulse,
  output logic       tx_rdy_set_pulse,
  output logic       tx_stat_clr_pulse,
  output logic       mr_ptr_rst_pulse,
  output logic       rx_reset_pulse,
  output logic       tx_reset_pulse,
  output logic       err_clr_pulse,
  output logic       brk_chg_clr_pulse,
  output logic       tx_hold_off,
  output logic       tx_line_low
);
  cmd_s cmd;
  logic [NUM_STROBES-1:0] stb;

  uart_cmd_decode u_dec (
    .we    (cmd_we),
    .wdata (cmd_wdata[6:0]),
    .cmd   (cmd)
  );

  uart_cmd_strobes #(.NSTB(NUM_STROBES)) u_stb (
    .clk    (clk),
    .rst_n  (rst_n),
    .misc   (cmd.misc),
    .strobe (stb)
  );

  uart_cmd_enables u_en (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd               (cmd),
    .tx_shifting       (tx_shifting),
    .thr_loaded        (thr_loaded),
    .rx_enable         (rx_enable),
    .tx_enable         (tx_enable),
    .tx_running        (tx_running),
    .rx_hunt_pulse     (rx_hunt_pulse),
    .tx_rdy_set_pulse  (tx_rdy_set_pulse),
    .tx_stat_clr_pulse (tx_stat_clr_pulse)
  );

  uart_brk_seq #(.START_TICKS(START_TICKS), .MARK_TICKS(MARK_TICKS)) u_brk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (cmd.misc == MC_BRKGO),
    .stop_req    (cmd.misc == MC_BRKEND),
    .kill_req    (cmd.misc == MC_TXRST),
    .tx_en_q     (tx_enable),
    .bit_tick    (bit_tick),
    .tx_shifting (tx_shifting),
    .thr_loaded  (thr_loaded),
    .tx_hold_off (tx_hold_off),
    .tx_line_low (tx_line_low)
  );

  assign mr_ptr_rst_pulse  = stb[0];
  assign rx_reset_pulse    = stb[1];
  assign tx_reset_pulse    = stb[2];
  assign err_clr_pulse     = stb[3];
  assign brk_chg_clr_pulse = stb[4];
endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_wdata,
  input logic       tx_shifting,
  input logic       thr_loaded,
  input logic       rx_enable,
  input logic       tx_enable,
  input logic       tx_running,
  input logic       rx_hunt_pulse,
  input logic       tx_rdy_set_pulse,
  input logic       tx_stat_clr_pulse,
  input logic       mr_ptr_rst_pulse,
  input logic       rx_reset_pulse,
  input logic       tx_reset_pulse,
  input logic       err_clr_pulse,
  input logic       brk_chg_clr_pulse,
  input logic       tx_hold_off,
  input logic       tx_line_low
);
  logic [4:0] misc_stb;
  assign misc_stb = {mr_ptr_rst_pulse, rx_reset_pulse, tx_reset_pulse,
                     err_clr_pulse, brk_chg_clr_pulse};

  assert_rx_off_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[1] |=> !rx_enable);

  assert_tx_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[2] && !cmd_wdata[3] |=> tx_enable && tx_rdy_set_pulse);

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(misc_stb));

  assert_hunt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[0] && !cmd_wdata[1] |=> rx_enable && rx_hunt_pulse);

  assert_drain_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_running) |-> tx_reset_pulse || $past(!tx_shifting && !thr_loaded));

  assert_reserved_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata == 8'h80 |=> $stable(rx_enable) && $stable(tx_enable)
      && misc_stb == 5'd0 && !rx_hunt_pulse && !tx_stat_clr_pulse);

  assert_low_after_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_line_low) |-> $past(!tx_shifting && !thr_loaded));

  assert_mark_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_line_low) && !tx_reset_pulse |-> tx_hold_off);

  assert_low_implies_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_line_low |-> tx_hold_off);

  assert_strobe_after_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_stb != 5'd0 || rx_hunt_pulse || tx_rdy_set_pulse || tx_stat_clr_pulse)
      |-> $past(cmd_we));
endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_we            (cmd_we),
  .cmd_wdata         (cmd_wdata),
  .tx_shifting       (tx_shifting),
  .thr_loaded        (thr_loaded),
  .rx_enable         (rx_enable),
  .tx_enable         (tx_enable),
  .tx_running        (tx_running),
  .rx_hunt_pulse     (rx_hunt_pulse),
  .tx_rdy_set_pulse  (tx_rdy_set_pulse),
  .tx_stat_clr_pulse (tx_stat_clr_pulse),
  .mr_ptr_rst_pulse  (mr_ptr_rst_pulse),
  .rx_reset_pulse    (rx_reset_pulse),
  .tx_reset_pulse    (tx_reset_pulse),
  .err_clr_pulse     (err_clr_pulse),
  .brk_chg_clr_pulse (brk_chg_clr_pulse),
  .tx_hold_off       (tx_hold_off),
  .tx_line_low       (tx_line_low)
);

// File: tb/tb_uart_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_uart_cmd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic bit_tick = 1'b0;
  logic tx_shifting = 1'b0;
  logic thr_loaded = 1'b0;
  logic rx_enable, tx_enable, tx_running, rx_hunt_pulse, tx_rdy_set_pulse;
  logic tx_stat_clr_pulse, mr_ptr_rst_pulse, rx_reset_pulse, tx_reset_pulse;
  logic err_clr_pulse, brk_chg_clr_pulse, tx_hold_off, tx_line_low;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .bit_tick(bit_tick), .tx_shifting(tx_shifting), .thr_loaded(thr_loaded),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .tx_running(tx_running),
    .rx_hunt_pulse(rx_hunt_pulse), .tx_rdy_set_pulse(tx_rdy_set_pulse),
    .tx_stat_clr_pulse(tx_stat_clr_pulse), .mr_ptr_rst_pulse(mr_ptr_rst_pulse),
    .rx_reset_pulse(rx_reset_pulse), .tx_reset_pulse(tx_reset_pulse),
    .err_clr_pulse(err_clr_pulse), .brk_chg_clr_pulse(brk_chg_clr_pulse),
    .tx_hold_off(tx_hold_off), .tx_line_low(tx_line_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = b;
    @(negedge clk);
    cmd_we = 1'b0;
    cmd_wdata = 8'h00;
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  function automatic int strobes();
    return {mr_ptr_rst_pulse, rx_reset_pulse, tx_reset_pulse, err_clr_pulse,
            brk_chg_clr_pulse, rx_hunt_pulse, tx_rdy_set_pulse, tx_stat_clr_pulse};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R1 rx_enable", rx_enable, 0);
    chk("reset R2 tx_enable", tx_enable, 0);
    chk("reset R13 strobes", strobes(), 0);
    chk("reset R9 line", tx_line_low, 0);

    // full sweep of command bytes from every starting enable pair
    for (int pr = 0; pr < 2; pr++) begin
      for (int pt = 0; pt < 2; pt++) begin
        for (int b = 0; b < 256; b++) begin
          int m, er, et;
          wr(8'(8'h30 | (pr != 0 ? 1 : 2) | (pt != 0 ? 4 : 8)));
          wr(8'(b));
          m = (b >> 4) & 7;
          er = pr;
          if (m == 2) er = 0;
          if ((b & 1) != 0) er = 1;
          if ((b & 2) != 0) er = 0;
          et = pt;
          if (m == 3) et = 0;
          if ((b & 4) != 0) et = 1;
          if ((b & 8) != 0) et = 0;
          chk("R1 R4 R7 rx_enable", rx_enable, er);
          chk("R2 R4 R7 tx_enable", tx_enable, et);
          chk("R6 tx_running idle", tx_running, et);
          chk("R5 rx_hunt_pulse", rx_hunt_pulse, ((b & 3) == 1) ? 1 : 0);
          chk("R2 tx_rdy_set_pulse", tx_rdy_set_pulse, ((b & 12) == 4) ? 1 : 0);
          chk("R2 tx_stat_clr_pulse", tx_stat_clr_pulse, ((b & 8) != 0) ? 1 : 0);
          chk("R3 mr_ptr_rst_pulse", mr_ptr_rst_pulse, (m == 1) ? 1 : 0);
          chk("R3 rx_reset_pulse", rx_reset_pulse, (m == 2) ? 1 : 0);
          chk("R3 tx_reset_pulse", tx_reset_pulse, (m == 3) ? 1 : 0);
          chk("R3 err_clr_pulse", err_clr_pulse, (m == 4) ? 1 : 0);
          chk("R3 brk_chg_clr_pulse", brk_chg_clr_pulse, (m == 5) ? 1 : 0);
          chk("R8 R9 tx_hold_off", tx_hold_off, (m == 6 && pt != 0) ? 1 : 0);
          chk("R9 tx_line_low", tx_line_low, 0);
          @(negedge clk);
          chk("R13 strobes idle", strobes(), 0);
        end
      end
    end

    // break from idle transmitter
    wr(8'h30); wr(8'h04);
    wr(8'h60);
    chk("R9 hold at start", tx_hold_off, 1);
    chk("R9 line before ticks", tx_line_low, 0);
    tick();
    chk("R9 line after one tick", tx_line_low, 0);
    tick();
    chk("R9 line after two ticks", tx_line_low, 1);
    repeat (4) @(negedge clk);
    chk("R11 line holds without stop", tx_line_low, 1);
    wr(8'h70);
    chk("R11 line low until tick", tx_line_low, 1);
    tick();
    chk("R11 line released", tx_line_low, 0);
    chk("R11 mark hold", tx_hold_off, 1);
    tick();
    chk("R11 hold released", tx_hold_off, 0);

    // break waiting for queued traffic
    tx_shifting = 1'b1;
    wr(8'h60);
    chk("R10 wait hold", tx_hold_off, 0);
    chk("R10 wait line", tx_line_low, 0);
    tick();
    chk("R10 tick ignored while busy", tx_line_low, 0);
    tx_shifting = 1'b0;
    @(negedge clk);
    chk("R10 line after quiet", tx_line_low, 1);
    wr(8'h30);
    chk("R12 reset releases line", tx_line_low, 0);
    chk("R12 reset releases hold", tx_hold_off, 0);

    // start refused while disabled
    wr(8'h60);
    chk("R8 refused start", tx_hold_off, 0);
    tick(); tick();
    chk("R8 no line low", tx_line_low, 0);

    // stop cancels pending break
    wr(8'h04); wr(8'h60);
    chk("R12 pending hold", tx_hold_off, 1);
    wr(8'h70);
    chk("R12 cancelled hold", tx_hold_off, 0);
    tick(); tick();
    chk("R12 cancelled line", tx_line_low, 0);

    // graceful disable
    tx_shifting = 1'b1;
    wr(8'h08);
    chk("R6 tx_enable off", tx_enable, 0);
    chk("R6 still running", tx_running, 1);
    chk("R2 stat clear", tx_stat_clr_pulse, 1);
    tx_shifting = 1'b0;
    thr_loaded = 1'b1;
    @(negedge clk);
    chk("R6 running with holding reg", tx_running, 1);
    thr_loaded = 1'b0;
    @(negedge clk);
    chk("R6 running ends", tx_running, 0);
    wr(8'h04); wr(8'h08);
    chk("R6 idle disable", tx_running, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule